// File: doc/BRIEF.md
# Absolute-Encoder Serial Reader with Cable Diagnostics

This block is the controller end of a point-to-point synchronous serial link to a position sensor. When asked to read, it drives a train of clock pulses on a line that rests high. The sensor answers one data bit per rising clock edge, most significant bit first. The block collects the word and hands it to the rest of the chip with a one-cycle strobe. The length of each clock half-period comes from a system-clock divider, so the link rate can be set anywhere from about 100 kHz to 2 MHz.

Each read pulses the clock once more than the word has bits. After that extra pulse the sensor must hold its data line low. The block also checks the line level just before a read starts, where an idle sensor holds it high. A low level there points to a broken wire. A high level after the extra pulse points to a short circuit.

After every read the block waits for a programmable pause before it starts the next one. Setting that pause longer than the sensor's freeze timeout gives a fresh value on each read. A read request that arrives while a read is running, or during the pause, is held until the pause ends. In an optional double mode the block clocks two frames back to back from the same frozen value. It returns the second frame and raises a mismatch flag if the two frames differ.

Top module: `ssi_reader`

## Requirements
- R1: Out of reset and whenever no read is running, `sclk_o` is high and `busy_o` is low; `valid_o` is low after reset.
- R2: A read drives P clock pulses, where P = WORD_W+1 in single mode and 2*(WORD_W+1) in double mode. Each pulse starts with a falling edge and has a low phase and a high phase of H system cycles each, where H = `half_div_i` (0 counts as 1). `busy_o` is high for exactly 2*H*P cycles.
- R3: The data line is sampled at the end of the high phase of each of the first WORD_W pulses of a frame and shifted in MSB first. The completed word appears on `word_o` at the strobe and holds until the next strobe.
- R4: `valid_o` is a single-cycle pulse, asserted in the first cycle in which `busy_o` is low again after a read.
- R5: If `sdata_i` is low in the cycle the read is launched, `fault_open_o` is 1 at the strobe; otherwise it is 0.
- R6: If `sdata_i` is high when sampled at the end of the high phase of any frame's extra (WORD_W+1-th) pulse, `fault_short_o` is 1 at the strobe; otherwise it is 0.
- R7: After a read, the next one starts no sooner than `pause_i`+1 cycles later: `busy_o` stays low for exactly `pause_i`+1 cycles when a request is pending. A `start_i` pulse received while busy or pausing is held and serviced then.
- R8: With `dbl_i` high at launch, both frames are read back to back and `word_o` is the second frame. `mismatch_o` is 1 at the strobe exactly when the two frames differ, and 0 in single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Read request, one cycle or longer |
| dbl_i | input | 1 | Double-read mode, sampled at launch |
| half_div_i | input | DIV_W | Clock half-period in system cycles (0 counts as 1), sampled at launch |
| pause_i | input | PAUSE_W | Minimum idle cycles after a read, minus one |
| sdata_i | input | 1 | Data line from the sensor, already synchronized |
| sclk_o | output | 1 | Link clock, idles high |
| busy_o | output | 1 | High while a pulse train runs |
| valid_o | output | 1 | One-cycle strobe for a finished read |
| word_o | output | WORD_W | Captured word |
| fault_open_o | output | 1 | Line was low before the read |
| fault_short_o | output | 1 | Line stayed high after an extra pulse |
| mismatch_o | output | 1 | Double-read frames differed |

## Verification
The bench sweeps many word values at every half-period from the degenerate 0 up to 3. It counts busy cycles and falling clock edges, so an off-by-one in the phase count or a missing extra pulse shows up as a wrong length rather than a wrong word. Forcing the line low or high finds a design that checks the idle level at the wrong moment or misses the trailing level: such a design gives a wrong fault flag or a word that is not all zeros or all ones. Requests made during a read are checked by measuring the idle gap with pause values 0 and 30. A design that dropped a held request would hang, and one that ignored the pause would give a short gap. Double reads with equal and with differing frames catch a design that returns the first frame or compares the wrong registers.

// File: rtl/ssi_pkg.sv
// Shared types for the serial encoder reader.
package ssi_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } ssi_state_e;
endpackage

// File: rtl/ssi_phase_timer.sv
// Half-period timer: counts system cycles within each clock phase and emits
// a tick on the last cycle of a phase. The phase length is latched at the
// launch of a read, so divider changes in mid-read have no effect.
module ssi_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic             run_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] lim_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == lim_q - DIV_W'(1));

    // Latch the phase length; a zero setting is raised to one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_q <= DIV_W'(1);
        else if (load_i)
            lim_q <= (half_div_i == '0) ? DIV_W'(1) : half_div_i;
    end

    // Count cycles inside the current phase, restarting at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i || !run_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

    assert_phase_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < lim_q));
endmodule

// File: rtl/ssi_ctrl.sv
// Read sequencer: launches a pulse train when a request is pending and the
// pause has run out, shapes the link clock from timer ticks, tracks bit and
// frame position, and reloads the pause counter after each read.
// Assumes tick_i comes from ssi_phase_timer loaded on launch_o.
module ssi_ctrl
    import ssi_pkg::*;
#(
    parameter int WORD_W  = 13,
    parameter int PAUSE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               dbl_i,
    input  logic [PAUSE_W-1:0] pause_i,
    input  logic               tick_i,
    output logic               launch_o,
    output logic               run_o,
    output logic               sclk_o,
    output logic               smp_o,
    output logic               trail_o,
    output logic               frame2_o,
    output logic               dbl_o,
    output logic               fin_o
);
    localparam int BIT_W = $clog2(WORD_W + 1);

    ssi_state_e         state_q;
    logic               sclk_q;
    logic [BIT_W-1:0]   bit_q;
    logic               frame2_q;
    logic               dbl_q;
    logic               pend_q;
    logic [PAUSE_W-1:0] pause_q;

    assign launch_o = (state_q == ST_IDLE) && (pend_q || start_i) && (pause_q == '0);
    assign run_o    = (state_q == ST_BURST);
    assign smp_o    = run_o && tick_i && sclk_q;
    assign trail_o  = (bit_q == BIT_W'(WORD_W));
    assign fin_o    = smp_o && trail_o && (frame2_q || !dbl_q);
    assign sclk_o   = sclk_q;
    assign frame2_o = frame2_q;
    assign dbl_o    = dbl_q;

    // Sequence the pulse train: state, clock level, bit and frame position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sclk_q   <= 1'b1;
            bit_q    <= '0;
            frame2_q <= 1'b0;
            dbl_q    <= 1'b0;
        end else if (launch_o) begin
            state_q  <= ST_BURST;
            sclk_q   <= 1'b0;
            bit_q    <= '0;
            frame2_q <= 1'b0;
            dbl_q    <= dbl_i;
        end else if (run_o && tick_i) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else if (fin_o) begin
                state_q <= ST_IDLE;
            end else begin
                sclk_q <= 1'b0;
                if (trail_o) begin
                    bit_q    <= '0;
                    frame2_q <= 1'b1;
                end else begin
                    bit_q <= bit_q + BIT_W'(1);
                end
            end
        end
    end

    // Hold a read request until it can be launched.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (launch_o)
            pend_q <= 1'b0;
        else if (start_i)
            pend_q <= 1'b1;
    end

    // Load the pause after a read and count it down while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pause_q <= '0;
        else if (fin_o)
            pause_q <= pause_i;
        else if (state_q == ST_IDLE && pause_q != '0)
            pause_q <= pause_q - PAUSE_W'(1);
    end

    assert_idle_clock_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> sclk_q);

    assert_launch_after_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> ($past(pause_q) == '0));

    assert_bit_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= BIT_W'(WORD_W));
endmodule

// File: rtl/ssi_capture.sv
// Data path: shifts in sampled bits MSB first, records the idle level at
// launch and the trailing level of each frame, keeps the first frame for
// the double-read compare, and registers the result with a strobe.
// Assumes sdata_i is synchronous to clk.
module ssi_capture #(
    parameter int WORD_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_i,
    input  logic              launch_i,
    input  logic              smp_i,
    input  logic              trail_i,
    input  logic              frame2_i,
    input  logic              dbl_i,
    input  logic              fin_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic              open_o,
    output logic              short_o,
    output logic              mismatch_o
);
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] first_q;
    logic              open_acc_q;
    logic              short_acc_q;
    logic              valid_q;
    logic [WORD_W-1:0] word_q;
    logic              open_q;
    logic              short_q;
    logic              mis_q;

    // Shift data bits in and keep the first frame for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            first_q <= '0;
        end else if (launch_i) begin
            sh_q <= '0;
        end else if (smp_i) begin
            if (!trail_i)
                sh_q <= {sh_q[WORD_W-2:0], sdata_i};
            else if (!frame2_i)
                first_q <= sh_q;
        end
    end

    // Accumulate the line-fault evidence over the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_acc_q  <= 1'b0;
            short_acc_q <= 1'b0;
        end else if (launch_i) begin
            open_acc_q  <= ~sdata_i;
            short_acc_q <= 1'b0;
        end else if (smp_i && trail_i) begin
            short_acc_q <= short_acc_q | sdata_i;
        end
    end

    // Publish the finished read with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            word_q  <= '0;
            open_q  <= 1'b0;
            short_q <= 1'b0;
            mis_q   <= 1'b0;
        end else begin
            valid_q <= fin_i;
            if (fin_i) begin
                word_q  <= sh_q;
                open_q  <= open_acc_q;
                short_q <= short_acc_q | sdata_i;
                mis_q   <= dbl_i && (sh_q != first_q);
            end
        end
    end

    assign valid_o    = valid_q;
    assign word_o     = word_q;
    assign open_o     = open_q;
    assign short_o    = short_q;
    assign mismatch_o = mis_q;

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    assert_word_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(word_q));

    assert_mismatch_needs_double_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && mis_q) |-> $past(dbl_i));
endmodule

// File: rtl/ssi_reader.sv
// Top level of the encoder reader: phase timer, sequencer and data path.
// Assumes sdata_i has been synchronized to clk by the line receiver stage
// and that half_div_i and dbl_i are valid in the launch cycle.
module ssi_reader #(
    parameter int WORD_W  = 13,
    parameter int DIV_W   = 8,
    parameter int PAUSE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               dbl_i,
    input  logic [DIV_W-1:0]   half_div_i,
    input  logic [PAUSE_W-1:0] pause_i,
    input  logic               sdata_i,
    output logic               sclk_o,
    output logic               busy_o,
    output logic               valid_o,
    output logic [WORD_W-1:0]  word_o,
    output logic               fault_open_o,
    output logic               fault_short_o,
    output logic               mismatch_o
);
    logic launch, run, tick, smp, trail, frame2, dbl_q, fin;

    ssi_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (launch),
        .half_div_i (half_div_i),
        .run_i      (run),
        .tick_o     (tick)
    );

    ssi_ctrl #(.WORD_W(WORD_W), .PAUSE_W(PAUSE_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .dbl_i    (dbl_i),
        .pause_i  (pause_i),
        .tick_i   (tick),
        .launch_o (launch),
        .run_o    (run),
        .sclk_o   (sclk_o),
        .smp_o    (smp),
        .trail_o  (trail),
        .frame2_o (frame2),
        .dbl_o    (dbl_q),
        .fin_o    (fin)
    );

    ssi_capture #(.WORD_W(WORD_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdata_i    (sdata_i),
        .launch_i   (launch),
        .smp_i      (smp),
        .trail_i    (trail),
        .frame2_i   (frame2),
        .dbl_i      (dbl_q),
        .fin_i      (fin),
        .valid_o    (valid_o),
        .word_o     (word_o),
        .open_o     (fault_open_o),
        .short_o    (fault_short_o),
        .mismatch_o (mismatch_o)
    );

    assign busy_o = run;

    assert_valid_at_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> valid_o);

    assert_clock_high_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sclk_o);
endmodule

// File: tb/test_ssi_reader.sv
// Bench: a behavioural sensor answers the link clock; reads are swept over
// word values, half-periods and modes, and results are checked at the ports.
module test_ssi_reader;
    localparam int W   = 8;
    localparam int DW  = 8;
    localparam int PW  = 12;
    localparam int TM  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dbl = 1'b0;
    logic [DW-1:0] hdiv = '0;
    logic [PW-1:0] pause = PW'(30);
    logic          sdata;
    logic          sclk, busy, valid, fopen, fshort, mis;
    logic [W-1:0]  word;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Sensor model state.
    logic [W-1:0] val_a = '0;
    logic [W-1:0] val_b = '0;
    int           line_mode = 0;
    logic         sd = 1'b1;
    logic         sclk_prev = 1'b1;
    int           edge_k = 0;
    int           hi_cnt = 0;

    always #2.5 clk = ~clk;

    ssi_reader #(.WORD_W(W), .DIV_W(DW), .PAUSE_W(PW)) i_ssi_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dbl_i(dbl),
        .half_div_i(hdiv), .pause_i(pause), .sdata_i(sdata),
        .sclk_o(sclk), .busy_o(busy), .valid_o(valid), .word_o(word),
        .fault_open_o(fopen), .fault_short_o(fshort), .mismatch_o(mis)
    );

    assign sdata = (line_mode == 1) ? 1'b0 : (line_mode == 2) ? 1'b1 : sd;

    // Sensor: one bit per rising clock, low after the word, back to idle on timeout.
    always @(negedge clk) begin
        if (sclk && !sclk_prev) begin
            int pos, fr;
            logic [W-1:0] cur;
            edge_k = edge_k + 1;
            pos = (edge_k - 1) % (W + 1);
            fr  = (edge_k - 1) / (W + 1);
            cur = (fr == 0) ? val_a : val_b;
            sd  = (pos < W) ? cur[W-1-pos] : 1'b0;
            hi_cnt = 0;
        end else if (sclk) begin
            hi_cnt = hi_cnt + 1;
            if (hi_cnt > TM) begin
                edge_k = 0;
                sd = 1'b1;
            end
        end else begin
            hi_cnt = 0;
        end
        sclk_prev = sclk;
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: run did not complete, actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_tests = n_tests + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One read with expected results computed from the requirements.
    task automatic run_read(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic dmode, input int hd, input int mode);
        int h, p, busy_cnt, falls;
        logic prev;
        logic [W-1:0] exp_word;
        repeat (40) @(negedge clk);
        val_a = a; val_b = b; line_mode = mode;
        dbl = dmode; hdiv = DW'(hd);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!busy) @(negedge clk);
        h = (hd == 0) ? 1 : hd;
        p = (W + 1) * (dmode ? 2 : 1);
        busy_cnt = 0; falls = 0; prev = 1'b1;
        while (busy) begin
            busy_cnt++;
            if (prev && !sclk) falls++;
            prev = sclk;
            @(negedge clk);
        end
        exp_word = (mode == 1) ? '0 : (mode == 2) ? '1 : (dmode ? b : a);
        check("R2 busy length", busy_cnt, 2 * h * p);
        check("R2 pulse count", falls, p);
        check("R4 valid at busy drop", valid, 1);
        check("R3 word", word, exp_word);
        check("R5 open flag", fopen, (mode == 1));
        check("R6 short flag", fshort, (mode == 2));
        check("R8 mismatch", mis, (dmode && mode == 0 && a != b));
        @(negedge clk);
        check("R4 valid single cycle", valid, 0);
        check("R1 idle clock high", sclk, 1);
        check("R3 word holds", word, exp_word);
        line_mode = 0;
    endtask

    // Measure the idle gap when a request is made during a read.
    task automatic gap_test(input int pz);
        int gap;
        repeat (40) @(negedge clk);
        val_a = 8'h5A; val_b = 8'h5A; dbl = 1'b0; hdiv = DW'(2);
        pause = PW'(pz);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!busy) @(negedge clk);
        repeat (3) @(negedge clk);
        start = 1'b1;               // request while busy: must be held (R7)
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        gap = 0;
        while (!busy) begin
            gap++;
            check("R1 clock high in pause", sclk, 1);
            @(negedge clk);
        end
        check("R7 held request gap", gap, pz + 1);
        while (busy) @(negedge clk);
        pause = PW'(30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset clock high", sclk, 1);
        check("R1 reset busy low", busy, 0);
        check("R1 reset valid low", valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", busy, 0);
        // Sweep of word values over half-periods 0..3 (R2, R3).
        for (int hd = 0; hd < 4; hd++) begin
            for (int k = 0; k < 32; k++) begin
                run_read(W'(k * 37 + 5 + hd), '0, 1'b0, hd, 0);
            end
        end
        run_read(8'h00, 8'h00, 1'b0, 1, 0);
        run_read(8'hFF, 8'hFF, 1'b0, 3, 0);
        // Line faults (R5, R6).
        run_read(8'h3C, 8'h3C, 1'b0, 2, 1);
        run_read(8'h3C, 8'h3C, 1'b0, 1, 2);
        run_read(8'h81, 8'h81, 1'b0, 2, 0);
        // Double reads (R8).
        for (int hd = 1; hd < 4; hd++) begin
            run_read(8'hA5, 8'hA5, 1'b1, hd, 0);
            run_read(8'hA5, 8'hA4, 1'b1, hd, 0);
            run_read(8'h01, 8'h80, 1'b1, hd, 0);
        end
        run_read(8'h77, 8'h77, 1'b1, 2, 2);
        // Held requests and pause spacing (R7).
        gap_test(30);
        gap_test(0);
        gap_test(7);
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule